// File: doc/BRIEF.md
# Multichannel Frame Injection FIFO

This block moves frames of I/Q samples from a CPU clock domain into a DSP clock domain, where an upsampler consumes them. Software first writes ten staging slots, which hold an X and a Y sample for each of five channels. It then issues a single push strobe. The push commits all ten staged samples to the queue as one indivisible frame. On the DSP side, each pop request takes one whole frame.

Errors on either side are recorded in two sticky flags. Overflow means a push arrived while the queue was full. Underflow means a pop arrived while the queue was empty. One clear strobe resets both flags. A flags byte gives the writer a "writable" bit that is high while the queue has room for another frame. Pointers cross between the domains in Gray code through two-flop synchronizers. The underflow flag lives in the DSP domain and is synchronized back to the CPU side. The clear is carried into the DSP domain by a toggle pulse synchronizer.

Top module: `frame_inj_fifo`

## Requirements
- R1: A staging write with `stg_we_i` high loads `stg_data_i` into slot `stg_slot_i`, where slot = 2*(channel-1) + 0 for X and + 1 for Y. Slot numbers 10 and above are ignored. Staging writes without a push never change the queue contents.
- R2: A push captures the ten staged values as they stood before that clock edge. A staging write in the same cycle as the push is not part of that frame. Frames leave the queue in push order, and slot i appears on `frame_o[16*i+15:16*i]`.
- R3: A push while the queue is full discards the frame and sets `ovf_o` one CPU cycle later. `ovf_o` then stays high until a clear.
- R4: A pop while the queue is empty keeps `frame_valid_o` low and leaves `frame_o` unchanged. It also sets the sticky underflow flag, which appears on `unf_o` within three CPU cycles.
- R5: `clear_i` drops `ovf_o` one CPU cycle later and clears the underflow flag. The cleared underflow state shows on `unf_o` within a few cycles of both clocks.
- R6: `flags_o[1]` is high while the queue is not full, as seen from the CPU side. All other bits of `flags_o` read 0.
- R7: A pop on a non-empty queue raises `frame_valid_o` for exactly one DSP cycle after that edge, with the head frame on `frame_o`. With no pop, `frame_valid_o` stays low.
- R8: After reset, `ovf_o` = 0, `unf_o` = 0, `flags_o` = 8'h02, `frame_valid_o` = 0 and `frame_o` = 0.
- R9: The queue holds DEPTH = 16 frames. Sixteen pushes into an empty queue are accepted, and a seventeenth overflows.
- R10: The write pointer changes at most one Gray bit per CPU cycle. A pushed frame becomes poppable, and a popped slot becomes free to the writer, within three cycles of the receiving clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys_i | input | 1 | CPU-side clock |
| clk_dsp_i | input | 1 | DSP-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| stg_we_i | input | 1 | Staging slot write enable |
| stg_slot_i | input | 4 | Staging slot index |
| stg_data_i | input | 16 | Staging sample value |
| push_i | input | 1 | One-cycle strobe that commits the staged frame |
| clear_i | input | 1 | One-cycle strobe that clears both sticky flags |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag, synchronized into the CPU domain |
| flags_o | output | 8 | Bit 1 = writable; all other bits 0 |
| pop_i | input | 1 | DSP-side frame request |
| frame_o | output | 160 | Last popped frame |
| frame_valid_o | output | 1 | One-cycle pulse when a new frame is on `frame_o` |

## Verification
`ovf_o` and the writable bit are sampled at the CPU falling edge that follows the push or clear. `frame_valid_o` and `frame_o` are sampled at the DSP falling edge after the pop edge. Results that cross a domain need more time. These are queue occupancy as seen by the other side and `unf_o`, whose worst case is three receiving-clock cycles, or pulse-sync plus back-sync for a clear. The bench waits ten CPU cycles after every operation before it checks them. This keeps the model exact, so every check compares a settled value against the bench's own queue and flag model.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  timeunit 1ns; timeprecision 1ps;
  localparam int SLOT_PER_CH = 2;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  timeunit 1ns; timeprecision 1ps;
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/fifo_pulse_xfer.sv
module fifo_pulse_xfer (
  input  logic src_clk_i,
  input  logic dst_clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic pulse_o
);
  timeunit 1ns; timeprecision 1ps;
  logic tog_q, tog_sync, tog_d_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else if (pulse_i) tog_q <= ~tog_q;
  end

  fifo_sync2 #(.W(1)) u_sync (
    .clk_i(dst_clk_i), .rst_ni(rst_ni), .d_i(tog_q), .q_o(tog_sync)
  );

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_d_q <= 1'b0;
    else tog_d_q <= tog_sync;
  end
  assign pulse_o = tog_sync ^ tog_d_q;
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          clear_i,
  input  logic [AW:0]   rgray_sync_i,
  output logic [AW:0]   wgray_o,
  output logic [AW-1:0] waddr_o,
  output logic          wen_o,
  output logic          full_o,
  output logic          ovf_o
);
  timeunit 1ns; timeprecision 1ps;
  localparam int PW = AW + 1;
  logic [AW:0] wbin_q, wbin_nxt, wgray_q;
  logic        ovf_q;

  assign full_o   = (wgray_q == {~rgray_sync_i[AW:AW-1], rgray_sync_i[AW-2:0]});
  assign wen_o    = push_i & ~full_o;
  assign wbin_nxt = wbin_q + PW'(wen_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= PW'(fifo_pkg::to_gray(32'(wbin_nxt)));
      if (clear_i) ovf_q <= 1'b0;
      else if (push_i && full_o) ovf_q <= 1'b1;
    end
  end

  assign wgray_o = wgray_q;
  assign waddr_o = wbin_q[AW-1:0];
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          clr_i,
  input  logic [AW:0]   wgray_sync_i,
  output logic [AW:0]   rgray_o,
  output logic [AW-1:0] raddr_o,
  output logic          ren_o,
  output logic          empty_o,
  output logic          unf_o
);
  timeunit 1ns; timeprecision 1ps;
  localparam int PW = AW + 1;
  logic [AW:0] rbin_q, rbin_nxt, rgray_q;
  logic        unf_q;

  assign empty_o  = (rgray_q == wgray_sync_i);
  assign ren_o    = pop_i & ~empty_o;
  assign rbin_nxt = rbin_q + PW'(ren_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      unf_q   <= 1'b0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= PW'(fifo_pkg::to_gray(32'(rbin_nxt)));
      if (clr_i) unf_q <= 1'b0;
      else if (pop_i && empty_o) unf_q <= 1'b1;
    end
  end

  assign rgray_o = rgray_q;
  assign raddr_o = rbin_q[AW-1:0];
  assign unf_o   = unf_q;
endmodule

// File: rtl/frame_inj_fifo.sv
module frame_inj_fifo #(
  parameter int CHANNELS   = 5,
  parameter int SAMPLE_W   = 16,
  parameter int DEPTH_LOG2 = 4,
  localparam int SLOTS     = CHANNELS * fifo_pkg::SLOT_PER_CH,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int FRAME_W   = SLOTS * SAMPLE_W
) (
  input  logic                clk_sys_i,
  input  logic                clk_dsp_i,
  input  logic                rst_ni,
  input  logic                stg_we_i,
  input  logic [SLOT_W-1:0]   stg_slot_i,
  input  logic [SAMPLE_W-1:0] stg_data_i,
  input  logic                push_i,
  input  logic                clear_i,
  output logic                ovf_o,
  output logic                unf_o,
  output logic [7:0]          flags_o,
  input  logic                pop_i,
  output logic [FRAME_W-1:0]  frame_o,
  output logic                frame_valid_o
);
  timeunit 1ns; timeprecision 1ps;
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int AW    = DEPTH_LOG2;

  logic [FRAME_W-1:0] stg_flat;
  logic [FRAME_W-1:0] mem [DEPTH];
  logic [AW:0]        wgray, rgray, wgray_sync, rgray_sync;
  logic [AW-1:0]      waddr, raddr;
  logic               wen, ren, full_w, empty_w, unf_dsp, clr_dsp;
  logic [FRAME_W-1:0] frame_q;
  logic               valid_q;

  // staging slots
  for (genvar i = 0; i < SLOTS; i++) begin : g_stg
    logic [SAMPLE_W-1:0] slot_q;
    always_ff @(posedge clk_sys_i or negedge rst_ni) begin
      if (!rst_ni) slot_q <= '0;
      else if (stg_we_i && (stg_slot_i == SLOT_W'(i))) slot_q <= stg_data_i;
    end
    assign stg_flat[i*SAMPLE_W +: SAMPLE_W] = slot_q;
  end

  fifo_wr_ctl #(.AW(AW)) u_wr (
    .clk_i(clk_sys_i), .rst_ni(rst_ni), .push_i(push_i), .clear_i(clear_i),
    .rgray_sync_i(rgray_sync), .wgray_o(wgray), .waddr_o(waddr),
    .wen_o(wen), .full_o(full_w), .ovf_o(ovf_o)
  );

  always_ff @(posedge clk_sys_i) begin
    if (wen) mem[waddr] <= stg_flat;
  end

  fifo_sync2 #(.W(AW+1)) u_w2r (
    .clk_i(clk_dsp_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_sync)
  );
  fifo_sync2 #(.W(AW+1)) u_r2w (
    .clk_i(clk_sys_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_sync)
  );

  fifo_pulse_xfer u_clr (
    .src_clk_i(clk_sys_i), .dst_clk_i(clk_dsp_i), .rst_ni(rst_ni),
    .pulse_i(clear_i), .pulse_o(clr_dsp)
  );

  fifo_rd_ctl #(.AW(AW)) u_rd (
    .clk_i(clk_dsp_i), .rst_ni(rst_ni), .pop_i(pop_i), .clr_i(clr_dsp),
    .wgray_sync_i(wgray_sync), .rgray_o(rgray), .raddr_o(raddr),
    .ren_o(ren), .empty_o(empty_w), .unf_o(unf_dsp)
  );

  always_ff @(posedge clk_dsp_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= ren;
      if (ren) frame_q <= mem[raddr];
    end
  end

  fifo_sync2 #(.W(1)) u_unf (
    .clk_i(clk_sys_i), .rst_ni(rst_ni), .d_i(unf_dsp), .q_o(unf_o)
  );

  assign frame_o       = frame_q;
  assign frame_valid_o = valid_q;
  assign flags_o       = {6'b0, ~full_w, 1'b0};
endmodule

// File: rtl/frame_inj_fifo_chk.sv
module frame_inj_fifo_chk #(
  parameter int AW = 4,
  parameter int FW = 160
) (
  input logic          clk_sys_i,
  input logic          clk_dsp_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          clear_i,
  input logic          pop_i,
  input logic          ovf_o,
  input logic [7:0]    flags_o,
  input logic [FW-1:0] frame_o,
  input logic          frame_valid_o,
  input logic          empty,
  input logic [AW:0]   wgray
);
  timeunit 1ns; timeprecision 1ps;

  // R3
  ovf_sticky_chk: assert property (@(posedge clk_sys_i) disable iff (!rst_ni)
    ovf_o && !clear_i |=> ovf_o);
  // R3
  ovf_set_chk: assert property (@(posedge clk_sys_i) disable iff (!rst_ni)
    push_i && !flags_o[1] && !clear_i |=> ovf_o);
  // R5
  ovf_clear_chk: assert property (@(posedge clk_sys_i) disable iff (!rst_ni)
    clear_i |=> !ovf_o);
  // R4
  unf_no_valid_chk: assert property (@(posedge clk_dsp_i) disable iff (!rst_ni)
    pop_i && empty |=> !frame_valid_o && $stable(frame_o));
  // R7
  no_pop_no_valid_chk: assert property (@(posedge clk_dsp_i) disable iff (!rst_ni)
    !pop_i |=> !frame_valid_o && $stable(frame_o));
  // R10
  wgray_step_chk: assert property (@(posedge clk_sys_i) disable iff (!rst_ni)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

bind frame_inj_fifo frame_inj_fifo_chk #(.AW(DEPTH_LOG2), .FW(FRAME_W)) u_chk (
  .clk_sys_i(clk_sys_i), .clk_dsp_i(clk_dsp_i), .rst_ni(rst_ni),
  .push_i(push_i), .clear_i(clear_i), .pop_i(pop_i), .ovf_o(ovf_o),
  .flags_o(flags_o), .frame_o(frame_o), .frame_valid_o(frame_valid_o),
  .empty(empty_w), .wgray(wgray)
);

// File: tb/tb_frame_inj_fifo.sv
module tb_frame_inj_fifo;
  timeunit 1ns; timeprecision 1ps;
  localparam int SLOTS = 10;
  localparam int DEPTH = 16;
  localparam int FW    = 160;

  logic clk_sys = 0, clk_dsp = 0, rst_ni = 0;
  logic stg_we = 0, push = 0, clear = 0, pop = 0;
  logic [3:0]  stg_slot = 0;
  logic [15:0] stg_data = 0;
  logic ovf, unf, fvalid;
  logic [7:0]  flags;
  logic [FW-1:0] frame;

  int checks = 0, failures = 0;
  logic [15:0]   m_stg [SLOTS];
  logic [FW-1:0] m_q [$];
  logic [FW-1:0] m_last;
  logic m_ovf, m_unf;

  always #2 clk_sys = ~clk_sys;  // 250 MHz
  always #3 clk_dsp = ~clk_dsp;

  frame_inj_fifo dut (
    .clk_sys_i(clk_sys), .clk_dsp_i(clk_dsp), .rst_ni(rst_ni),
    .stg_we_i(stg_we), .stg_slot_i(stg_slot), .stg_data_i(stg_data),
    .push_i(push), .clear_i(clear), .ovf_o(ovf), .unf_o(unf), .flags_o(flags),
    .pop_i(pop), .frame_o(frame), .frame_valid_o(fvalid)
  );

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] pack_stg();
    logic [FW-1:0] f;
    for (int i = 0; i < SLOTS; i++) f[i*16 +: 16] = m_stg[i];
    return f;
  endfunction

  task automatic settle();
    repeat (10) @(negedge clk_sys);
  endtask

  task automatic stage(input int slot, input logic [15:0] d);
    @(negedge clk_sys);
    stg_we = 1; stg_slot = 4'(slot); stg_data = d;
    @(negedge clk_sys);
    stg_we = 0;
    if (slot < SLOTS) m_stg[slot] = d;
  endtask

  // push, optionally with a same-cycle staging write
  task automatic do_push(input bit with_wr, input int slot, input logic [15:0] d);
    @(negedge clk_sys);
    push = 1;
    if (with_wr) begin stg_we = 1; stg_slot = 4'(slot); stg_data = d; end
    if (m_q.size() == DEPTH) m_ovf = 1;
    else m_q.push_back(pack_stg());
    if (with_wr && slot < SLOTS) m_stg[slot] = d;
    @(negedge clk_sys);
    push = 0; stg_we = 0;
    chk("R3 ovf after push", FW'(ovf), FW'(m_ovf));
    chk("R6 writable flag", FW'(flags), FW'({6'b0, m_q.size() < DEPTH, 1'b0}));
    settle();
  endtask

  task automatic do_pop();
    logic [FW-1:0] exp_f;
    bit had;
    had = (m_q.size() != 0);
    @(negedge clk_dsp);
    pop = 1;
    @(negedge clk_dsp);
    pop = 0;
    if (had) begin
      exp_f = m_q.pop_front();
      m_last = exp_f;
      chk("R7 valid on pop", FW'(fvalid), FW'(1));
      chk("R2 frame order/content", frame, exp_f);
    end else begin
      m_unf = 1;
      chk("R4 valid low on empty pop", FW'(fvalid), FW'(0));
      chk("R4 frame held", frame, m_last);
    end
    @(negedge clk_dsp);
    chk("R7 valid one cycle", FW'(fvalid), FW'(0));
    settle();
    chk("R4 unf flag", FW'(unf), FW'(m_unf));
    chk("R10 writable after pop", FW'(flags[1]), FW'(m_q.size() < DEPTH));
  endtask

  task automatic do_clear();
    @(negedge clk_sys);
    clear = 1;
    @(negedge clk_sys);
    clear = 0;
    m_ovf = 0; m_unf = 0;
    chk("R5 ovf cleared", FW'(ovf), FW'(0));
    settle();
    chk("R5 unf cleared", FW'(unf), FW'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk_sys);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7315));
    for (int i = 0; i < SLOTS; i++) m_stg[i] = '0;
    m_last = '0; m_ovf = 0; m_unf = 0;
    repeat (3) @(negedge clk_sys);
    rst_ni = 1;
    settle();
    // R8 reset state
    chk("R8 ovf", FW'(ovf), FW'(0));
    chk("R8 unf", FW'(unf), FW'(0));
    chk("R8 flags", FW'(flags), FW'(8'h02));
    chk("R8 valid", FW'(fvalid), FW'(0));
    chk("R8 frame", frame, '0);

    // R1: staging only, incl. out-of-range slots, leaves queue empty
    for (int s = 0; s < 16; s++) stage(s, 16'(16'hA000 + s * 16'h111));
    do_pop();
    do_clear();

    // R9: fill to capacity, then one more overflows (R3)
    for (int n = 0; n < DEPTH; n++) begin
      stage(n % SLOTS, 16'(n * 16'h0101 + 1));
      do_push(0, 0, 0);
    end
    chk("R9 full after 16", FW'(flags[1]), FW'(0));
    do_push(0, 0, 0);
    chk("R9 overflow on 17th", FW'(ovf), FW'(1));
    do_clear();
    for (int n = 0; n < DEPTH; n++) do_pop();
    do_pop();  // underflow
    do_clear();

    // R2: same-cycle staging write excluded from the pushed frame
    do_push(1, 3, 16'hBEEF);
    do_push(0, 0, 0);
    do_pop();
    do_pop();

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 4) stage(int'($urandom % 12), 16'($urandom));
      else if (op < 6) do_push(($urandom % 3) == 0, int'($urandom % 12), 16'($urandom));
      else if (op < 9) do_pop();
      else do_clear();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule